// File: doc/BRIEF.md
# GPIO Port Controller with Atomic Set/Clear Aliases

This block controls a group of 8-bit general-purpose I/O ports behind a plain 32-bit register bus. Each port has one combined status-and-control word and two write-only alias words. The status-and-control word holds, from most to least significant byte:

- the pin directions
- the output latch
- a copy of the pins taken just after reset
- the live, synchronized pin levels

The set alias drives chosen output bits high. The clear alias drives chosen output bits low. Neither alias needs a read-modify-write, so a bit-banging routine can toggle one pin without disturbing its neighbours.

Each pin drives an output-enable and an output value to its pad and receives the pad level back. Pad levels pass through a two-flop synchronizer before software can see them. Reads are combinational on the address, and a write takes effect on the clock edge that samples it.

Top module: `gpio_alias_port`

## Requirements
- R1: After reset every direction bit and every output latch bit is 0: `pad_oe` and `pad_out` are all zero, and bits 31:16 of each port's data word read as zero.
- R2: Port p's data word is at address `p*0x10`. A write to it loads bits 31:24 into the direction byte and bits 23:16 into the output byte. `pad_oe` shows the direction byte, where 1 means output, and `pad_out` shows the output byte.
- R3: A write to the set alias at `p*0x10+0x4` forces to 1 every output bit whose write-data bit in 23:16 is 1. It leaves every output bit with a 0 there unchanged.
- R4: A write to the clear alias at `p*0x10+0x8` forces to 0 every output bit whose write-data bit in 23:16 is 1. It leaves every output bit with a 0 there unchanged.
- R5: Alias write bits 31:24 and 15:0 are ignored. In particular, an alias write never changes any direction bit.
- R6: Data word write bits 15:0 are ignored. The reset copy and the live input fields keep their values.
- R7: A write changes only the port whose address it hits. A cycle without a write changes no direction or output bit.
- R8: A pad level appears in bits 7:0 of its port's data word exactly two clock edges after it is applied, and not after one.
- R9: Bits 15:8 hold the pad levels sampled on the first clock edge after reset is released. They keep that value until the next reset, and the next reset captures afresh.
- R10: Reads of alias addresses return 0. Addresses with offset 0xC, non-zero bits 1:0, or a port index of `NUM_PORTS` or more read as 0, and writes to them change nothing.
- R11: A set write followed in the very next cycle by a clear write to the same port applies both, in order. The output after the first edge shows the set, and the output after the second edge shows the clear applied on top of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_oe | output | 8*NUM_PORTS | Per-pin output enable, port p at bits 8p+7:8p |
| pad_out | output | 8*NUM_PORTS | Per-pin output value |
| pad_in | input | 8*NUM_PORTS | Per-pin pad level, asynchronous |

## Verification
The bench goes after the set and clear masks with every 8-bit mask value, while the reserved bytes are filled with ones. A design that touched direction bits from an alias, or that replaced the latch instead of merging it, shows a wrong direction or output byte at once. Back-to-back set-then-clear writes catch a design that drops or reorders the second access.

Input timing is checked one edge after a pad change and again two edges after it, so a synchronizer that is one stage short or one stage long is caught. Unmapped and alias addresses are read back and written with all ones. A second reset with a new pad pattern shows whether the reset copy is captured again or stuck.

// File: rtl/gpio_alias_pkg.sv
package gpio_alias_pkg;

  localparam int unsigned LANE_W = 8;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_SET  = 2'd1,
    REG_CLR  = 2'd2,
    REG_NONE = 2'd3
  } reg_kind_e;

  // Offset inside a port's 16-byte window -> register kind
  function automatic reg_kind_e kind_of(input logic [3:0] off);
    case (off)
      4'h0:    return REG_DATA;
      4'h4:    return REG_SET;
      4'h8:    return REG_CLR;
      default: return REG_NONE;
    endcase
  endfunction

  function automatic logic [LANE_W-1:0] merge_set(input logic [LANE_W-1:0] cur,
                                                  input logic [LANE_W-1:0] mask);
    return cur | mask;
  endfunction

  function automatic logic [LANE_W-1:0] merge_clr(input logic [LANE_W-1:0] cur,
                                                  input logic [LANE_W-1:0] mask);
    return cur & ~mask;
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(input logic [LANE_W-1:0] dir,
                                                  input logic [LANE_W-1:0] dout,
                                                  input logic [LANE_W-1:0] snap,
                                                  input logic [LANE_W-1:0] live);
    return {dir, dout, snap, live};
  endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_alias_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_PORTS  = 3,
  parameter int PORT_IDX_W = 2
) (
  input  logic [ADDR_W-1:0]     addr,
  output logic                  hit,
  output logic [PORT_IDX_W-1:0] port_idx,
  output reg_kind_e             kind
);
  localparam int FIELD_W = ADDR_W - 4;

  logic [FIELD_W-1:0] port_field;

  assign port_field = addr[ADDR_W-1:4];
  assign kind       = kind_of(addr[3:0]);
  assign port_idx   = port_field[PORT_IDX_W-1:0];
  assign hit        = (kind != REG_NONE) && (int'(port_field) < NUM_PORTS);
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpio_alias_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dat_evt,
  input  logic              set_evt,
  input  logic              clr_evt,
  input  logic [LANE_W-1:0] wr_dir,
  input  logic [LANE_W-1:0] wr_mask,
  input  logic [LANE_W-1:0] pad_in,
  output logic [LANE_W-1:0] dir_q,
  output logic [LANE_W-1:0] out_q,
  output logic [LANE_W-1:0] snap_q,
  output logic [LANE_W-1:0] live_q
);
  logic snap_done;
  logic any_evt;

  assign any_evt = dat_evt | set_evt | clr_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
    end else if (dat_evt) begin
      dir_q <= wr_dir;
      out_q <= wr_mask;
    end else if (set_evt) begin
      out_q <= merge_set(out_q, wr_mask);
    end else if (clr_evt) begin
      out_q <= merge_clr(out_q, wr_mask);
    end
  end

  // Capture the pads once, on the first edge after reset is released
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q    <= '0;
      snap_done <= 1'b0;
    end else if (!snap_done) begin
      snap_q    <= pad_in;
      snap_done <= 1'b1;
    end
  end

  gpio_in_sync #(.WIDTH(LANE_W)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(pad_in),
    .sync_out(live_q)
  );

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> ((out_q & $past(wr_mask)) == $past(wr_mask)))
    else $error("set alias did not raise bits"); // R3
  AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> ((out_q & ~$past(wr_mask)) == ($past(out_q) & ~$past(wr_mask))))
    else $error("set alias disturbed unmasked bits"); // R3
  AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> ((out_q & $past(wr_mask)) == '0))
    else $error("clear alias did not lower bits"); // R4
  AST_CLR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> ((out_q & ~$past(wr_mask)) == ($past(out_q) & ~$past(wr_mask))))
    else $error("clear alias disturbed unmasked bits"); // R4
  AST_ALIAS_KEEPS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt || clr_evt) |=> $stable(dir_q))
    else $error("alias write changed direction"); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !any_evt |=> ($stable(out_q) && $stable(dir_q)))
    else $error("port state moved without a write"); // R7
  AST_SNAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    snap_done |=> $stable(snap_q))
    else $error("reset copy changed after capture"); // R9
endmodule

// File: rtl/gpio_alias_port.sv
module gpio_alias_port
  import gpio_alias_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_PORTS = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_wr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  output logic [NUM_PORTS*8-1:0]     pad_oe,
  output logic [NUM_PORTS*8-1:0]     pad_out,
  input  logic [NUM_PORTS*8-1:0]     pad_in
);
  localparam int PORT_IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int PINS       = NUM_PORTS * LANE_W;

  logic                  dec_hit;
  logic [PORT_IDX_W-1:0] dec_port;
  reg_kind_e             dec_kind;

  logic [WORD_W-1:0]     port_word [NUM_PORTS];
  logic [PINS-1:0]       snap_all;

  // Named events for the checks below
  logic alias_rsvd_wr;
  logic data_low_wr;
  logic unmapped_wr;

  gpio_addr_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_PORTS (NUM_PORTS),
    .PORT_IDX_W(PORT_IDX_W)
  ) u_dec (
    .addr    (bus_addr),
    .hit     (dec_hit),
    .port_idx(dec_port),
    .kind    (dec_kind)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic sel;
    logic [LANE_W-1:0] dir_b, out_b, snap_b, live_b;

    assign sel = bus_wr && dec_hit && (int'(dec_port) == p);

    gpio_port_bank u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .dat_evt(sel && (dec_kind == REG_DATA)),
      .set_evt(sel && (dec_kind == REG_SET)),
      .clr_evt(sel && (dec_kind == REG_CLR)),
      .wr_dir (bus_wdata[31:24]),
      .wr_mask(bus_wdata[23:16]),
      .pad_in (pad_in[p*LANE_W +: LANE_W]),
      .dir_q  (dir_b),
      .out_q  (out_b),
      .snap_q (snap_b),
      .live_q (live_b)
    );

    assign pad_oe  [p*LANE_W +: LANE_W] = dir_b;
    assign pad_out [p*LANE_W +: LANE_W] = out_b;
    assign snap_all[p*LANE_W +: LANE_W] = snap_b;
    assign port_word[p] = pack_word(dir_b, out_b, snap_b, live_b);
  end

  always_comb begin
    bus_rdata = '0;
    if (dec_hit && (dec_kind == REG_DATA)) bus_rdata = port_word[dec_port];
  end

  assign alias_rsvd_wr = bus_wr && dec_hit && (dec_kind != REG_DATA) &&
                         ((|bus_wdata[31:24]) || (|bus_wdata[15:0]));
  assign data_low_wr   = bus_wr && dec_hit && (dec_kind == REG_DATA) && (|bus_wdata[15:0]);
  assign unmapped_wr   = bus_wr && !dec_hit;

  AST_NONDATA_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_hit && (dec_kind == REG_DATA)) |-> (bus_rdata == '0))
    else $error("non-data address returned data"); // R10
  AST_UNMAPPED_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped_wr |=> ($stable(pad_oe) && $stable(pad_out)))
    else $error("unmapped write changed state"); // R10
  AST_ALIAS_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    alias_rsvd_wr |=> $stable(pad_oe))
    else $error("alias reserved bits changed direction"); // R5
  AST_DATA_LOW_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    data_low_wr |=> $stable(snap_all))
    else $error("data write reached reset copy"); // R6
endmodule

// File: tb/sim_gpio_alias_port.sv
module sim_gpio_alias_port;
  localparam int NP = 3;
  localparam int AW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic            bus_wr = 1'b0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NP*8-1:0] pad_oe, pad_out;
  logic [NP*8-1:0] pad_in = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] e_dir [NP];
  logic [7:0] e_out [NP];
  logic [7:0] e_snap[NP];
  logic [7:0] e_in  [NP];

  always #2 clk = ~clk;

  gpio_alias_port #(.ADDR_W(AW), .NUM_PORTS(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_oe(pad_oe),
    .pad_out(pad_out), .pad_in(pad_in)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic check_port(input int p, input string req);
    logic [31:0] w;
    bus_read(AW'(p*16), w);
    chk(req, w, {e_dir[p], e_out[p], e_snap[p], e_in[p]});
    chk(req, {24'd0, pad_oe[p*8 +: 8]}, {24'd0, e_dir[p]});
    chk(req, {24'd0, pad_out[p*8 +: 8]}, {24'd0, e_out[p]});
  endtask

  task automatic check_all(input string req);
    for (int p = 0; p < NP; p++) check_port(p, req);
  endtask

  task automatic do_reset(input logic [NP*8-1:0] pat);
    @(negedge clk);
    pad_in = pat; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      e_dir[p] = 8'h00; e_out[p] = 8'h00;
      e_snap[p] = pat[p*8 +: 8]; e_in[p] = pat[p*8 +: 8];
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] w;
    logic [7:0]  keep;

    // R1 and R9: reset state and reset copy
    do_reset(24'h3C_5A_96);
    check_all("R1");
    pad_in = 24'h11_22_33;
    @(negedge clk);
    @(negedge clk);
    for (int p = 0; p < NP; p++) e_in[p] = pad_in[p*8 +: 8];
    check_all("R9");

    // R2, R6, R7: data word writes with junk in the low bytes
    for (int p = 0; p < NP; p++) begin
      for (int v = 0; v < 256; v += 15) begin
        bus_write(AW'(p*16), {8'(v), ~8'(v), 8'hAB, 8'hCD});
        e_dir[p] = 8'(v); e_out[p] = ~8'(v);
        check_port(p, "R2");
      end
      check_all("R7");
    end

    // R3 and R5: every set mask with all reserved bits at one
    e_dir[1] = 8'h5A;
    bus_write(8'h10, {8'h5A, 8'h00, 16'h0000});
    e_out[1] = 8'h00;
    for (int m = 0; m < 256; m++) begin
      bus_write(8'h14, {8'hFF, 8'(m), 16'hFFFF});
      e_out[1] = e_out[1] | 8'(m);
      chk("R3", {24'd0, pad_out[15:8]}, {24'd0, e_out[1]});
      chk("R5", {24'd0, pad_oe[15:8]}, {24'd0, e_dir[1]});
      if ((m % 32) == 31) begin
        bus_write(8'h10, {8'h5A, 8'h00, 16'h0000});
        e_out[1] = 8'h00;
      end
    end

    // R4 and R5: every clear mask from an all-ones start
    bus_write(8'h20, {8'hC3, 8'hFF, 16'h0000});
    e_dir[2] = 8'hC3; e_out[2] = 8'hFF;
    for (int m = 0; m < 256; m++) begin
      bus_write(8'h28, {8'hFF, 8'(m), 16'hFFFF});
      e_out[2] = e_out[2] & ~8'(m);
      chk("R4", {24'd0, pad_out[23:16]}, {24'd0, e_out[2]});
      chk("R5", {24'd0, pad_oe[23:16]}, {24'd0, e_dir[2]});
      if ((m % 32) == 31) begin
        bus_write(8'h20, {8'hC3, 8'hFF, 16'h0000});
        e_out[2] = 8'hFF;
      end
    end
    check_all("R7");

    // R10: alias and unmapped reads, unmapped writes
    bus_read(8'h04, w); chk("R10", w, 32'd0);
    bus_read(8'h18, w); chk("R10", w, 32'd0);
    bus_read(8'h0C, w); chk("R10", w, 32'd0);
    bus_read(8'h01, w); chk("R10", w, 32'd0);
    bus_read(8'h30, w); chk("R10", w, 32'd0);
    bus_write(8'h0C, 32'hFFFF_FFFF);
    bus_write(8'h02, 32'hFFFF_FFFF);
    bus_write(8'h21, 32'h0000_0000);
    bus_write(8'h30, 32'hFFFF_FFFF);
    bus_write(8'h34, 32'hFFFF_FFFF);
    bus_write(8'hF8, 32'hFFFF_FFFF);
    check_all("R10");

    // R11: set then clear in consecutive cycles, and clear then set
    keep = e_out[0];
    @(negedge clk);
    bus_addr = 8'h04; bus_wdata = {8'h00, 8'hF0, 16'h0}; bus_wr = 1'b1;
    @(negedge clk);
    chk("R11", {24'd0, pad_out[7:0]}, {24'd0, keep | 8'hF0});
    bus_addr = 8'h08; bus_wdata = {8'h00, 8'h30, 16'h0};
    @(negedge clk);
    bus_wr = 1'b0;
    e_out[0] = (keep | 8'hF0) & ~8'h30;
    chk("R11", {24'd0, pad_out[7:0]}, {24'd0, e_out[0]});
    @(negedge clk);
    bus_addr = 8'h08; bus_wdata = {8'h00, 8'h81, 16'h0}; bus_wr = 1'b1;
    @(negedge clk);
    chk("R11", {24'd0, pad_out[7:0]}, {24'd0, e_out[0] & ~8'h81});
    bus_addr = 8'h04; bus_wdata = {8'h00, 8'h81, 16'h0};
    @(negedge clk);
    bus_wr = 1'b0;
    e_out[0] = e_out[0] | 8'h81;
    chk("R11", {24'd0, pad_out[7:0]}, {24'd0, e_out[0]});
    check_all("R11");

    // R8: two-edge input latency on each port
    for (int p = 0; p < NP; p++) begin
      @(negedge clk);
      bus_addr = AW'(p*16);
      pad_in[p*8 +: 8] = ~e_in[p];
      @(negedge clk);
      #1 chk("R8", {24'd0, bus_rdata[7:0]}, {24'd0, e_in[p]});
      e_in[p] = ~e_in[p];
      @(negedge clk);
      #1 chk("R8", {24'd0, bus_rdata[7:0]}, {24'd0, e_in[p]});
    end
    check_all("R8");

    // R9: a second reset captures a new pattern
    do_reset(24'hA7_0F_E1);
    check_all("R9");
    pad_in = 24'h00_FF_00;
    repeat (2) @(negedge clk);
    for (int p = 0; p < NP; p++) e_in[p] = pad_in[p*8 +: 8];
    check_all("R9");

    finish_run();
  end
endmodule